// File: doc/BRIEF.md
# Lock-Protected System Control Register Bank

This block is the register bank of a board-level system controller. Software reaches it through a plain synchronous register port: a byte address, write data and a write strobe, with read data returned combinationally for the address currently presented. The two lowest address bits are ignored, so every register is a 32-bit word. The bank holds a static identity word, LED drive bits, two general configuration words, a software key register, a volatile and a non-volatile flag register, a reset-control register that can fire a one-cycle system reset request, a display-control register, card status bits and a free-running reference tick counter.

A 12-bit board variant code sits in bits 27:16 of the identity word, which is a parameter. The code decides whether the reset-control register exists and which data bit triggers a reset. It also fixes the writable mask and reset value of the display register, whether its low two bits drive a mux select output, and where the write-protect level appears in the card status word. The non-volatile flags ignore the ordinary reset and are cleared only by a separate power-on reset.

Top module: `sysctl_regbank`

## Requirements
- R1: Offset 0x00 reads the ID_WORD parameter. The variant code is bits 27:16 of that word.
- R2: Ordinary reset (rst_ni low) clears the LEDs, key, configuration words, volatile flags, reset level and tick counter. It sets the display register to 0x1F00, or to zero on variant 0x190. The non-volatile flags keep their value across it and are cleared only by por_ni low.
- R3: The key register at 0x20 stores 0xA05F when exactly 0x0000A05F is written. Any other write stores data[15:0] AND 0x7FFF. The bank counts as unlocked only while the key reads 0xA05F.
- R4: Volatile flags read at 0x30. A write to 0x30 ORs the data in, and a write to 0x34 clears the bits set in the data. The non-volatile flags behave the same way at 0x38 (set and read) and 0x3C (clear).
- R5: On variants 0x100, 0x178 and 0x182, a write to 0x40 while unlocked stores the data, and 0x40 reads it back. A write while locked changes nothing. An accepted write whose trigger bit is 1 raises sys_reset_req_o for exactly the following cycle. The trigger bit is data bit 8 on variant 0x100 and data bit 2 on variants 0x178 and 0x182.
- R6: On all other variants, 0x40 reads zero and ignores writes, even while unlocked, and no reset request is raised.
- R7: The display register at 0x50 has variant-dependent writable bits. On 0x100 and 0x140, every bit except 13:8 is writable. On 0x178 and 0x182, only bit 7 is writable. On 0x190 and on unrecognised codes, no bit is writable.
- R8: disp_sel_o carries display register bits 1:0 on variant 0x100 and is zero on every other variant.
- R9: Offset 0x48 reports the card-detect level in bit 0. The write-protect level appears in bit 2 on variants 0x100 and 0x140, and in bit 1 on all other variants.
- R10: Offset 0x5C reads a counter that advances by one on each clock edge at which ref_tick_i is high, and holds otherwise.
- R11: Offset 0x08 (LED, low LED_W bits, also driven on leds_o), 0x28 and 0x2C are read/write. Offset 0x44 always reads 0x00000001, and offset 0x88 always reads 0xFF000000.
- R12: Offsets outside this map, including the oscillator, flash and bridge offsets, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| por_ni | input | 1 | Active-low power-on reset for the non-volatile flags |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i |
| card_det_i | input | 1 | Card-detect level |
| card_wp_i | input | 1 | Card write-protect level |
| ref_tick_i | input | 1 | Reference tick enable |
| leds_o | output | LED_W | LED drive |
| disp_sel_o | output | 2 | Display format mux select |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Three instances are built with variant codes 0x100, 0x178 and 0x190, so one stimulus sequence separates the per-variant masks, trigger bits and status bit positions. A vector table covers key writes with the exact key, with a near miss and with all ones. It also covers set-then-clear flag patterns that overlap, and an all-ones then all-zeros display write that exposes the read-only field. Directed tests write reset control while locked and while unlocked, with the trigger bit set and with a non-trigger bit set. They also apply an ordinary reset and then a power-on reset to show which one clears the non-volatile flags.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW = 32;

  localparam logic [11:0] OFF_ID      = 12'h000;
  localparam logic [11:0] OFF_LED     = 12'h008;
  localparam logic [11:0] OFF_KEY     = 12'h020;
  localparam logic [11:0] OFF_CFG0    = 12'h028;
  localparam logic [11:0] OFF_CFG1    = 12'h02C;
  localparam logic [11:0] OFF_FLG_SET = 12'h030;
  localparam logic [11:0] OFF_FLG_CLR = 12'h034;
  localparam logic [11:0] OFF_NVF_SET = 12'h038;
  localparam logic [11:0] OFF_NVF_CLR = 12'h03C;
  localparam logic [11:0] OFF_RSTCTL  = 12'h040;
  localparam logic [11:0] OFF_BRIDGE  = 12'h044;
  localparam logic [11:0] OFF_CARD    = 12'h048;
  localparam logic [11:0] OFF_DISP    = 12'h050;
  localparam logic [11:0] OFF_TICKS   = 12'h05C;
  localparam logic [11:0] OFF_PROC1   = 12'h088;

  localparam logic [11:0] VAR_X100 = 12'h100;
  localparam logic [11:0] VAR_X140 = 12'h140;
  localparam logic [11:0] VAR_X178 = 12'h178;
  localparam logic [11:0] VAR_X182 = 12'h182;
  localparam logic [11:0] VAR_X190 = 12'h190;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;

  typedef struct packed {
    logic          rst_ctl_en;
    logic [4:0]    rst_trig;
    logic [DW-1:0] disp_wmask;
    logic [DW-1:0] disp_init;
    logic          sel_en;
    logic [4:0]    wp_bit;
  } var_cfg_t;
endpackage

// File: rtl/sysctl_variant.sv
module sysctl_variant
  import sysctl_pkg::*;
(
  input  logic [11:0] code_i,
  output var_cfg_t    cfg_o
);
  always_comb begin
    cfg_o            = '0;
    cfg_o.disp_init  = 32'h0000_1F00;
    cfg_o.wp_bit     = 5'd1;
    unique case (code_i)
      VAR_X100: begin
        cfg_o.rst_ctl_en = 1'b1;
        cfg_o.rst_trig   = 5'd8;
        cfg_o.disp_wmask = ~32'h0000_3F00;
        cfg_o.sel_en     = 1'b1;
        cfg_o.wp_bit     = 5'd2;
      end
      VAR_X140: begin
        cfg_o.disp_wmask = ~32'h0000_3F00;
        cfg_o.wp_bit     = 5'd2;
      end
      VAR_X178, VAR_X182: begin
        cfg_o.rst_ctl_en = 1'b1;
        cfg_o.rst_trig   = 5'd2;
        cfg_o.disp_wmask = 32'h0000_0080;
      end
      VAR_X190: cfg_o.disp_init = '0;
      default: ;
    endcase
  end
endmodule

// File: rtl/sysctl_setclr_reg.sv
module sysctl_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (set_i) q_o <= q_o | d_i;
    else if (clr_i) q_o <= q_o & ~d_i;
  end

  a_r4_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(d_i)) == $past(d_i)));
  a_r4_clr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(d_i)) == '0));
endmodule

// File: rtl/sysctl_tick_cnt.sv
module sysctl_tick_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  a_r10_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_o == $past(cnt_o) + 1'b1));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h0100_0000,
  parameter int unsigned LED_W   = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned CNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  input  logic              card_det_i,
  input  logic              card_wp_i,
  input  logic              ref_tick_i,
  output logic [LED_W-1:0]  leds_o,
  output logic [1:0]        disp_sel_o,
  output logic              sys_reset_req_o
);
  localparam logic [11:0] VAR_CODE = ID_WORD[27:16];
  localparam int unsigned NFLG     = 2;

  var_cfg_t cfg;
  sysctl_variant u_variant (.code_i(VAR_CODE), .cfg_o(cfg));

  logic [ADDR_W-1:0] a_w;
  assign a_w = addr_i & ~ADDR_W'(3);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic [LED_W-1:0] led_q;
  logic [15:0]      key_q;
  logic [31:0]      cfg0_q, cfg1_q, rlvl_q, disp_q;
  logic             req_q;
  logic             unlocked, rst_acc, wr_disp;

  assign unlocked = (key_q == UNLOCK_KEY[15:0]);
  assign rst_acc  = we_i && hit(a_w, OFF_RSTCTL) && cfg.rst_ctl_en && unlocked;
  assign wr_disp  = we_i && hit(a_w, OFF_DISP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q  <= '0;
      key_q  <= '0;
      cfg0_q <= '0;
      cfg1_q <= '0;
      rlvl_q <= '0;
      disp_q <= cfg.disp_init;
      req_q  <= 1'b0;
    end else begin
      req_q <= rst_acc && wdata_i[cfg.rst_trig];
      if (rst_acc) rlvl_q <= wdata_i;
      if (wr_disp) disp_q <= (disp_q & ~cfg.disp_wmask) | (wdata_i & cfg.disp_wmask);
      if (we_i && hit(a_w, OFF_LED))  led_q  <= wdata_i[LED_W-1:0];
      if (we_i && hit(a_w, OFF_CFG0)) cfg0_q <= wdata_i;
      if (we_i && hit(a_w, OFF_CFG1)) cfg1_q <= wdata_i;
      if (we_i && hit(a_w, OFF_KEY))
        key_q <= (wdata_i == UNLOCK_KEY) ? UNLOCK_KEY[15:0] : (wdata_i[15:0] & 16'h7FFF);
    end
  end

  // flag 0: volatile, flag 1: kept across rst_ni, cleared by power-on reset only
  logic [31:0] flg_q [NFLG];
  for (genvar g = 0; g < NFLG; g++) begin : g_flg
    localparam logic [11:0] SET_OFF = (g == 0) ? OFF_FLG_SET : OFF_NVF_SET;
    localparam logic [11:0] CLR_OFF = (g == 0) ? OFF_FLG_CLR : OFF_NVF_CLR;
    logic flg_rst_n;
    assign flg_rst_n = (g == 0) ? rst_ni : por_ni;
    sysctl_setclr_reg #(.W(32)) u_flg (
      .clk_i  (clk_i),
      .rst_ni (flg_rst_n),
      .set_i  (we_i && hit(a_w, SET_OFF)),
      .clr_i  (we_i && hit(a_w, CLR_OFF)),
      .d_i    (wdata_i),
      .q_o    (flg_q[g])
    );
  end

  logic [CNT_W-1:0] tick_cnt;
  sysctl_tick_cnt #(.W(CNT_W)) u_ticks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick_i),
    .cnt_o  (tick_cnt)
  );

  logic [31:0] card_w;
  always_comb begin
    card_w              = '0;
    card_w[0]           = card_det_i;
    card_w[cfg.wp_bit]  = card_wp_i;
  end

  always_comb begin
    rdata_o = '0;
    if      (hit(a_w, OFF_ID))      rdata_o = ID_WORD;
    else if (hit(a_w, OFF_LED))     rdata_o = 32'(led_q);
    else if (hit(a_w, OFF_KEY))     rdata_o = 32'(key_q);
    else if (hit(a_w, OFF_CFG0))    rdata_o = cfg0_q;
    else if (hit(a_w, OFF_CFG1))    rdata_o = cfg1_q;
    else if (hit(a_w, OFF_FLG_SET)) rdata_o = flg_q[0];
    else if (hit(a_w, OFF_NVF_SET)) rdata_o = flg_q[1];
    else if (hit(a_w, OFF_RSTCTL))  rdata_o = cfg.rst_ctl_en ? rlvl_q : '0;
    else if (hit(a_w, OFF_BRIDGE))  rdata_o = 32'h0000_0001;
    else if (hit(a_w, OFF_CARD))    rdata_o = card_w;
    else if (hit(a_w, OFF_DISP))    rdata_o = disp_q;
    else if (hit(a_w, OFF_TICKS))   rdata_o = 32'(tick_cnt);
    else if (hit(a_w, OFF_PROC1))   rdata_o = 32'hFF00_0000;
  end

  assign leds_o          = led_q;
  assign disp_sel_o      = cfg.sel_en ? disp_q[1:0] : 2'b00;
  assign sys_reset_req_o = req_q;

  a_r5_req_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> ($past(key_q) == UNLOCK_KEY[15:0] && $past(we_i)
               && $past(a_w) == ADDR_W'(OFF_RSTCTL)));
  a_r3_bad_key_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit(a_w, OFF_KEY) && wdata_i != UNLOCK_KEY) |=> !unlocked);
  a_r7_ro_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_disp |=> ((disp_q & ~cfg.disp_wmask) == $past(disp_q & ~cfg.disp_wmask)));
  a_r6_no_req_without_ctl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> cfg.rst_ctl_en);
endmodule

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;
  logic clk = 1'b0, rst_ni = 1'b0, por_ni = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we_a = 1'b0, we_b = 1'b0, we_c = 1'b0;
  logic card_det = 1'b0, card_wp = 1'b0, tick = 1'b0;
  logic [31:0] rd_a, rd_b, rd_c;
  logic [7:0]  led_a, led_b, led_c;
  logic [1:0]  sel_a, sel_b, sel_c;
  logic        req_a, req_b, req_c;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  sysctl_regbank #(.ID_WORD(32'h0100_0000)) u_sysctl_regbank (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we_a), .rdata_o(rd_a), .card_det_i(card_det), .card_wp_i(card_wp),
    .ref_tick_i(tick), .leds_o(led_a), .disp_sel_o(sel_a), .sys_reset_req_o(req_a));
  sysctl_regbank #(.ID_WORD(32'h0178_0000)) u_sysctl_regbank_b (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we_b), .rdata_o(rd_b), .card_det_i(card_det), .card_wp_i(card_wp),
    .ref_tick_i(tick), .leds_o(led_b), .disp_sel_o(sel_b), .sys_reset_req_o(req_b));
  sysctl_regbank #(.ID_WORD(32'h0190_0000)) u_sysctl_regbank_c (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we_c), .rdata_o(rd_c), .card_det_i(card_det), .card_wp_i(card_wp),
    .ref_tick_i(tick), .leds_o(led_c), .disp_sel_o(sel_c), .sys_reset_req_o(req_c));

  // {wr, addr, data, expected read, requirement number}
  localparam int NV = 35;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, 32'h0100_0000, 4'd1},   // R1 identity
    {1'b0, 12'h050, 32'h0, 32'h0000_1F00, 4'd2},   // R2 display reset value
    {1'b0, 12'h020, 32'h0, 32'h0000_0000, 4'd2},   // R2 key cleared
    {1'b1, 12'h008, 32'h0000_01A5, 32'h0, 4'd11},
    {1'b0, 12'h008, 32'h0, 32'h0000_00A5, 4'd11},  // R11 LED width
    {1'b1, 12'h028, 32'h1234_5678, 32'h0, 4'd11},
    {1'b0, 12'h028, 32'h0, 32'h1234_5678, 4'd11},
    {1'b1, 12'h02C, 32'hDEAD_BEEF, 32'h0, 4'd11},
    {1'b0, 12'h02C, 32'h0, 32'hDEAD_BEEF, 4'd11},
    {1'b1, 12'h030, 32'h0000_00F0, 32'h0, 4'd4},
    {1'b1, 12'h030, 32'h0000_0300, 32'h0, 4'd4},
    {1'b0, 12'h030, 32'h0, 32'h0000_03F0, 4'd4},   // R4 set accumulates
    {1'b1, 12'h034, 32'h0000_00A0, 32'h0, 4'd4},
    {1'b0, 12'h030, 32'h0, 32'h0000_0350, 4'd4},   // R4 clear
    {1'b1, 12'h038, 32'h0000_0081, 32'h0, 4'd4},
    {1'b1, 12'h03C, 32'h0000_0001, 32'h0, 4'd4},
    {1'b0, 12'h038, 32'h0, 32'h0000_0080, 4'd4},   // R4 nv flags
    {1'b1, 12'h020, 32'h0000_1234, 32'h0, 4'd3},
    {1'b0, 12'h020, 32'h0, 32'h0000_1234, 4'd3},   // R3
    {1'b1, 12'h020, 32'h0000_A05F, 32'h0, 4'd3},
    {1'b0, 12'h020, 32'h0, 32'h0000_A05F, 4'd3},
    {1'b1, 12'h020, 32'h0000_FFFF, 32'h0, 4'd3},
    {1'b0, 12'h020, 32'h0, 32'h0000_7FFF, 4'd3},
    {1'b1, 12'h040, 32'h0000_0100, 32'h0, 4'd5},
    {1'b0, 12'h040, 32'h0, 32'h0000_0000, 4'd5},   // R5 locked write ignored
    {1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0, 4'd7},
    {1'b0, 12'h050, 32'h0, 32'hFFFF_DFFF, 4'd7},   // R7 bits 13:8 read-only
    {1'b1, 12'h050, 32'h0000_0000, 32'h0, 4'd7},
    {1'b0, 12'h050, 32'h0, 32'h0000_1F00, 4'd7},
    {1'b0, 12'h044, 32'h0, 32'h0000_0001, 4'd11},  // R11 constants
    {1'b0, 12'h088, 32'h0, 32'hFF00_0000, 4'd11},
    {1'b1, 12'h00C, 32'h0000_0005, 32'h0, 4'd12},
    {1'b0, 12'h00C, 32'h0, 32'h0000_0000, 4'd12},  // R12 unmapped
    {1'b0, 12'h04C, 32'h0, 32'h0000_0000, 4'd12},
    {1'b0, 12'h0FC, 32'h0, 32'h0000_0000, 4'd12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    we_a = (sel == 0); we_b = (sel == 1); we_c = (sel == 2);
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0; we_c = 1'b0;
  endtask

  task automatic rd(input int sel, input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, (sel == 0) ? rd_a : (sel == 1) ? rd_b : rd_c, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; por_ni = 1'b1;
    #1;
    chk("R2 leds after reset", 32'(led_a), 32'h0);
    chk("R5 no request after reset", 32'(req_a), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) wr(0, VEC[i][79:68], VEC[i][67:36]);
      else rd(0, VEC[i][79:68], VEC[i][35:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end
    chk("R11 leds_o", 32'(led_a), 32'h0000_00A5);

    // R5: unlock then trigger on bit 8
    wr(0, 12'h020, 32'h0000_A05F);
    wr(0, 12'h040, 32'h0000_0100);
    chk("R5 request pulse", 32'(req_a), 32'h1);
    @(negedge clk);
    chk("R5 request single cycle", 32'(req_a), 32'h0);
    rd(0, 12'h040, 32'h0000_0100, "R5 level readback");
    wr(0, 12'h040, 32'h0000_0004);
    chk("R5 bit2 no trigger on 0x100", 32'(req_a), 32'h0);
    rd(0, 12'h040, 32'h0000_0004, "R5 level readback 2");

    // R8 mux select
    wr(0, 12'h050, 32'h0000_0003);
    chk("R8 select follows bits 1:0", 32'(sel_a), 32'h3);
    rd(0, 12'h050, 32'h0000_1F03, "R7 display low bits");

    // R9 card status
    card_det = 1'b1; card_wp = 1'b1;
    rd(0, 12'h048, 32'h0000_0005, "R9 wp bit2 on 0x100");
    rd(1, 12'h048, 32'h0000_0003, "R9 wp bit1 on 0x178");
    card_det = 1'b0;
    rd(0, 12'h048, 32'h0000_0004, "R9 card detect low");

    // R10 tick counter
    rd(0, 12'h05C, 32'h0, "R10 counter idle");
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    rd(0, 12'h05C, 32'h3, "R10 three ticks");
    repeat (2) @(negedge clk);
    rd(0, 12'h05C, 32'h3, "R10 hold");

    // R2 ordinary reset keeps nv flags
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    chk("R2 leds cleared", 32'(led_a), 32'h0);
    chk("R2 select cleared", 32'(sel_a), 32'h0);
    rd(0, 12'h038, 32'h0000_0080, "R2 nv flags kept");
    rd(0, 12'h030, 32'h0, "R2 flags cleared");
    rd(0, 12'h020, 32'h0, "R2 key cleared");
    rd(0, 12'h040, 32'h0, "R2 reset level cleared");
    rd(0, 12'h028, 32'h0, "R2 cfg cleared");
    rd(0, 12'h05C, 32'h0, "R2 counter cleared");
    rd(0, 12'h050, 32'h0000_1F00, "R2 display reset value");
    @(negedge clk); por_ni = 1'b0;
    @(negedge clk); por_ni = 1'b1;
    rd(0, 12'h038, 32'h0, "R2 power-on clears nv flags");

    // variant 0x178
    rd(1, 12'h000, 32'h0178_0000, "R1 identity b");
    wr(1, 12'h020, 32'h0000_A05F);
    wr(1, 12'h040, 32'h0000_0004);
    chk("R5 bit2 trigger on 0x178", 32'(req_b), 32'h1);
    chk("R5 other instance quiet", 32'(req_a), 32'h0);
    rd(1, 12'h040, 32'h0000_0004, "R5 level b");
    wr(1, 12'h050, 32'hFFFF_FFFF);
    rd(1, 12'h050, 32'h0000_1F80, "R7 only bit7 writable on 0x178");
    chk("R8 no select on 0x178", 32'(sel_b), 32'h0);

    // variant 0x190
    rd(2, 12'h050, 32'h0, "R2 display zero on 0x190");
    wr(2, 12'h050, 32'hFFFF_FFFF);
    rd(2, 12'h050, 32'h0, "R7 display ignores writes on 0x190");
    wr(2, 12'h020, 32'h0000_A05F);
    wr(2, 12'h040, 32'h0000_0104);
    chk("R6 no request on 0x190", 32'(req_c), 32'h0);
    rd(2, 12'h040, 32'h0, "R6 reset control reads zero");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule